// File: doc/BRIEF.md
# Partial-Write Parity Read-Modify-Write Controller

This controller sits between a write requester and a 64-bit synchronous memory that stores one even-parity bit per byte. A write that enables all eight bytes goes straight to memory one cycle after it is accepted. The controller computes the eight parity bits from the write data on the way.

A write that enables fewer bytes cannot produce full parity alone, so it starts a fixed read-modify-write sequence. The controller latches the request and reads the addressed double word. It checks the parity of the returned data, merges the enabled bytes into it, regenerates all eight parity bits and writes the result back.

A parity mismatch on the read does not stop the write-back. It sets a sticky error flag that holds until a clear input drops it. A page-hold setting chooses how the row is handled during the sequence:
- When the setting is nonzero, a keep-open signal holds the memory row open from the read through the write-back.
- When the setting is zero, a single close pulse lets the row be precharged between the read and the write.

Top module: `prmw_ctrl`

## Requirements
- R1: A request with `req_be` = 8'hFF is written to memory in the cycle after acceptance (`mem_en`=1, `mem_we`=1). `req_ready` stays high.
- R2: A request with any other `req_be` value, including 0, issues a read of `req_addr` in the cycle after acceptance (`mem_en`=1, `mem_we`=0).
- R3: The written-back double word takes byte i from `req_data` when `req_be[i]`=1, and from the read data otherwise.
- R4: Every memory write carries even parity per byte: `mem_wpar[i]` equals the XOR of `mem_wdata[8i+7:8i]`.
- R5: The write-back of a partial write appears exactly seven cycles after acceptance, six cycles later than a full write.
- R6: After a partial write is accepted, `req_ready` is low for six cycles and is high again in the write-back cycle.
- R7: If the parity read back does not match the read data, `par_err` rises and the write-back still completes with correct parity. With clean reads, `par_err` stays low.
- R8: `par_err` stays set across later writes until `clr_err` is asserted. It is then low in the next cycle.
- R9: With a nonzero `page_hold` at acceptance, `page_keep` is high in all seven cycles from the read through the write-back, and `mem_close` never pulses.
- R10: With `page_hold` = 0, `page_keep` stays low and `mem_close` is high for exactly one cycle, four cycles after acceptance.
- R11: After reset, `req_ready`=1, `mem_en`=0, `par_err`=0, `page_keep`=0 and `mem_close`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid | input | 1 | write request present |
| req_ready | output | 1 | request can be accepted |
| req_addr | input | AW | double-word address |
| req_data | input | 64 | write data |
| req_be | input | 8 | byte enables |
| page_hold | input | PHW | page-hold setting, nonzero keeps the row open |
| clr_err | input | 1 | clears the sticky parity error |
| mem_en | output | 1 | memory access this cycle |
| mem_we | output | 1 | access is a write |
| mem_addr | output | AW | memory address |
| mem_wdata | output | 64 | memory write data |
| mem_wpar | output | 8 | memory write parity |
| mem_rdata | input | 64 | read data, valid the cycle after a read |
| mem_rpar | input | 8 | read parity, valid with the data |
| page_keep | output | 1 | hold the memory row open |
| mem_close | output | 1 | precharge permitted between read and write |
| par_err | output | 1 | sticky read parity error |

## Verification
A wrong sequencer state shows up within one request as a write-back cycle other than seven after acceptance, or as the wrong number of `req_ready`-low cycles. A bad merge or parity generator leaves wrong bytes or parity bits in the memory model, which are compared right after the write. Page-handling faults appear as the wrong count of `page_keep` or `mem_close` cycles in the same window. Error-flag faults appear once a corrupted parity bit is read back.

// File: rtl/prmw_pkg.sv
package prmw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_CAP, ST_CHK, ST_MRG, ST_GEN, ST_WB, ST_WR
  } prmw_st_e;
endpackage

// File: rtl/prmw_pgen.sv
module prmw_pgen #(
  parameter int NB = 8
) (
  input  logic [NB*8-1:0] d,
  output logic [NB-1:0]   p
);
  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign p[i] = ^d[8*i +: 8];
  end
endmodule

// File: rtl/prmw_merge.sv
module prmw_merge #(
  parameter int NB = 8
) (
  input  logic [NB*8-1:0] old_d,
  input  logic [NB*8-1:0] new_d,
  input  logic [NB-1:0]   be,
  output logic [NB*8-1:0] out_d
);
  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign out_d[8*i +: 8] = be[i] ? new_d[8*i +: 8] : old_d[8*i +: 8];
  end
endmodule

// File: rtl/prmw_fsm.sv
module prmw_fsm
  import prmw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_part,
  output prmw_st_e state
);
  prmw_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start_part) st_d = ST_RD;
      ST_RD:   st_d = ST_CAP;
      ST_CAP:  st_d = ST_CHK;
      ST_CHK:  st_d = ST_MRG;
      ST_MRG:  st_d = ST_GEN;
      ST_GEN:  st_d = ST_WB;
      ST_WB:   st_d = ST_WR;
      ST_WR:   st_d = start_part ? ST_RD : ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;

  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_part |=> (st_q == ST_RD));
endmodule

// File: rtl/prmw_ctrl.sv
module prmw_ctrl
  import prmw_pkg::*;
#(
  parameter int AW  = 10,
  parameter int PHW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [63:0]   req_data,
  input  logic [7:0]    req_be,
  input  logic [PHW-1:0] page_hold,
  input  logic          clr_err,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  output logic [7:0]    mem_wpar,
  input  logic [63:0]   mem_rdata,
  input  logic [7:0]    mem_rpar,
  output logic          page_keep,
  output logic          mem_close,
  output logic          par_err
);
  localparam int NB = 8;
  localparam int DW = NB * 8;

  prmw_st_e st;
  logic accept, is_full, start_part;

  assign req_ready  = (st == ST_IDLE) || (st == ST_WR);
  assign accept     = req_valid && req_ready;
  assign is_full    = &req_be;
  assign start_part = accept && !is_full;

  prmw_fsm u_fsm (.clk(clk), .rst_n(rst_n), .start_part(start_part), .state(st));

  // request hold registers
  logic [AW-1:0] h_addr;
  logic [DW-1:0] h_data;
  logic [NB-1:0] h_be;
  logic          h_keep;
  logic          hold_en;
  assign hold_en = start_part;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_addr <= '0;
      h_data <= '0;
      h_be   <= '0;
      h_keep <= 1'b0;
    end else if (hold_en) begin
      h_addr <= req_addr;
      h_data <= req_data;
      h_be   <= req_be;
      h_keep <= (page_hold != '0);
    end
  end

  // read capture
  logic [DW-1:0] rd_d;
  logic [NB-1:0] rd_p;
  logic          cap_en;
  assign cap_en = (st == ST_CAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_d <= '0;
      rd_p <= '0;
    end else if (cap_en) begin
      rd_d <= mem_rdata;
      rd_p <= mem_rpar;
    end
  end

  // parity check
  logic [NB-1:0] rd_pcalc;
  prmw_pgen #(.NB(NB)) u_pchk (.d(rd_d), .p(rd_pcalc));

  logic err_set, err_d, err_q;
  assign err_set = (st == ST_CHK) && (rd_pcalc != rd_p);

  always_comb begin
    err_d = err_q;
    if (err_set)      err_d = 1'b1;
    else if (clr_err) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end
  assign par_err = err_q;

  // merge and parity regeneration
  logic [DW-1:0] mrg_w, mrg_q;
  logic [NB-1:0] mrg_pw, par_q;
  logic          mrg_en, gen_en;
  assign mrg_en = (st == ST_MRG);
  assign gen_en = (st == ST_GEN);

  prmw_merge #(.NB(NB)) u_merge (.old_d(rd_d), .new_d(h_data), .be(h_be), .out_d(mrg_w));
  prmw_pgen  #(.NB(NB)) u_pmrg  (.d(mrg_q), .p(mrg_pw));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mrg_q <= '0;
    else if (mrg_en) mrg_q <= mrg_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      par_q <= '0;
    else if (gen_en) par_q <= mrg_pw;
  end

  // memory command stage
  logic [NB-1:0] req_p;
  prmw_pgen #(.NB(NB)) u_preq (.d(req_data), .p(req_p));

  logic          en_d, we_d;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] wd_d;
  logic [NB-1:0] wp_d;

  always_comb begin
    en_d   = 1'b0;
    we_d   = 1'b0;
    addr_d = mem_addr;
    wd_d   = mem_wdata;
    wp_d   = mem_wpar;
    if (accept && is_full) begin
      en_d = 1'b1; we_d = 1'b1;
      addr_d = req_addr; wd_d = req_data; wp_d = req_p;
    end else if (start_part) begin
      en_d = 1'b1;
      addr_d = req_addr;
    end else if (st == ST_WB) begin
      en_d = 1'b1; we_d = 1'b1;
      addr_d = h_addr; wd_d = mrg_q; wp_d = par_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_wpar  <= '0;
    end else begin
      mem_en    <= en_d;
      mem_we    <= we_d;
      mem_addr  <= addr_d;
      mem_wdata <= wd_d;
      mem_wpar  <= wp_d;
    end
  end

  // page handling
  logic in_rmw;
  assign in_rmw    = (st != ST_IDLE);
  assign page_keep = in_rmw && h_keep;
  assign mem_close = (st == ST_MRG) && !h_keep;

  // R1
  full_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_full) |=> (mem_en && mem_we));
  // R5
  rd_to_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |-> ##6 (mem_en && mem_we));
  // R4
  wpar_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> (mem_wpar == {^mem_wdata[63:56], ^mem_wdata[55:48],
      ^mem_wdata[47:40], ^mem_wdata[39:32], ^mem_wdata[31:24], ^mem_wdata[23:16],
      ^mem_wdata[15:8], ^mem_wdata[7:0]}));
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !clr_err) |=> par_err);
  // R9
  page_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({page_keep, mem_close}));
  // R6
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_part |=> !req_ready);
endmodule

// File: tb/prmw_ctrl_test.sv
module prmw_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int PHW = 4;

  logic clk, rst_n;
  logic req_valid, req_ready, clr_err;
  logic [AW-1:0] req_addr;
  logic [63:0] req_data;
  logic [7:0] req_be;
  logic [PHW-1:0] page_hold;
  logic mem_en, mem_we, page_keep, mem_close, par_err;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic [7:0] mem_wpar, mem_rpar;

  int checks = 0;
  int errors = 0;

  prmw_ctrl #(.AW(AW), .PHW(PHW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_be(req_be),
    .page_hold(page_hold), .clr_err(clr_err), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wpar(mem_wpar),
    .mem_rdata(mem_rdata), .mem_rpar(mem_rpar), .page_keep(page_keep),
    .mem_close(mem_close), .par_err(par_err));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model
  logic [63:0] m_data [8];
  logic [7:0]  m_par  [8];
  logic        corrupt_en;
  logic [AW-1:0] corrupt_addr;
  logic [63:0] e_data [8];

  always @(posedge clk) begin
    if (mem_en && !mem_we) begin
      mem_rdata <= m_data[mem_addr];
      mem_rpar  <= m_par[mem_addr];
    end
    if (mem_en && mem_we) begin
      m_data[mem_addr] <= mem_wdata;
      m_par[mem_addr]  <= mem_wpar;
    end else if (corrupt_en) begin
      m_par[corrupt_addr] <= m_par[corrupt_addr] ^ 8'h01;
    end
  end

  function automatic logic [7:0] epar(input logic [63:0] d);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = ^d[8*i +: 8];
    return p;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [63:0] d,
                          input logic [7:0] be, input logic [PHW-1:0] ph);
    int wr_n, rdy_low, keep_n, close_n, close_at, rd_n;
    logic [63:0] exp_d;
    bit full;
    full = (be == 8'hFF);
    for (int i = 0; i < 8; i++)
      exp_d[8*i +: 8] = be[i] ? d[8*i +: 8] : e_data[a][8*i +: 8];
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d; req_be = be; page_hold = ph;
    @(posedge clk);
    wr_n = 0; rdy_low = 0; keep_n = 0; close_n = 0; close_at = 0; rd_n = 0;
    for (int n = 1; n <= 10; n++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (!req_ready) rdy_low++;
      if (page_keep) keep_n++;
      if (mem_close) begin close_n++; close_at = n; end
      if (mem_en && !mem_we && rd_n == 0) rd_n = n;
      if (mem_en && mem_we) begin wr_n = n; break; end
    end
    if (full) begin
      chk("R1 full write latency", 64'(wr_n), 64'd1);
      chk("R1 ready stays high", 64'(rdy_low), 64'd0);
    end else begin
      chk("R2 read after accept", 64'(rd_n), 64'd1);
      chk("R5 write-back latency", 64'(wr_n), 64'd7);
      chk("R6 ready low cycles", 64'(rdy_low), 64'd6);
      if (ph != '0) begin
        chk("R9 keep cycles", 64'(keep_n), 64'd7);
        chk("R9 no close", 64'(close_n), 64'd0);
      end else begin
        chk("R10 keep low", 64'(keep_n), 64'd0);
        chk("R10 close count", 64'(close_n), 64'd1);
        chk("R10 close cycle", 64'(close_at), 64'd4);
      end
    end
    @(posedge clk); #1;
    chk("R3 merged data", m_data[a], exp_d);
    chk("R4 stored parity", {56'd0, m_par[a]}, {56'd0, epar(exp_d)});
    e_data[a] = exp_d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_data = '0; req_be = '0;
    page_hold = '0; clr_err = 1'b0; corrupt_en = 1'b0; corrupt_addr = '0;
    mem_rdata = '0; mem_rpar = '0;
    for (int i = 0; i < 8; i++) begin m_data[i] = '0; m_par[i] = '0; e_data[i] = '0; end
    repeat (3) @(negedge clk);
    // R11
    chk("R11 ready", 64'(req_ready), 64'd1);
    chk("R11 mem_en", 64'(mem_en), 64'd0);
    chk("R11 par_err", 64'(par_err), 64'd0);
    chk("R11 page_keep", 64'(page_keep), 64'd0);
    chk("R11 mem_close", 64'(mem_close), 64'd0);
    @(negedge clk); rst_n = 1'b1;

    for (int a = 0; a < 8; a++)
      do_write(AW'(a), {8{8'(8'h11 * a + 8'h05)}} ^ 64'h0F1E2D3C4B5A6978, 8'hFF, 4'd0);

    for (int b = 0; b < 256; b++)
      do_write(AW'(b % 8), {8{8'(b)}} ^ (64'h9E3779B97F4A7C15 * 64'(b + 1)),
               8'(b), PHW'(b % 3));
    // R7 clean reads leave the flag low
    chk("R7 no error on clean reads", 64'(par_err), 64'd0);

    // R7 corrupt a stored parity bit, then a partial write there
    @(negedge clk); corrupt_en = 1'b1; corrupt_addr = 3'd2;
    @(negedge clk); corrupt_en = 1'b0;
    do_write(3'd2, 64'hA5A5A5A5A5A5A5A5, 8'h01, 4'd1);
    chk("R7 parity error raised", 64'(par_err), 64'd1);
    // R8 sticky across a clean partial write
    do_write(3'd3, 64'h123456789ABCDEF0, 8'h0C, 4'd0);
    chk("R8 error sticky", 64'(par_err), 64'd1);
    @(negedge clk); clr_err = 1'b1;
    @(negedge clk); clr_err = 1'b0;
    chk("R8 error cleared", 64'(par_err), 64'd0);
    do_write(3'd2, 64'h0, 8'hF0, 4'd2);
    chk("R8 stays clear after clean read", 64'(par_err), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule